// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block stands in for a small two-wire serial EEPROM of up to 256 bytes. The clock and data levels do not come from open-drain pins. Each time software writes a new pair of levels, the block receives a one-cycle update strobe carrying them. It answers with the data level it would leave on the wire. A host can therefore run a read transaction by toggling bits, without any real bus.

A single bit-position counter tracks the whole transaction. It first collects an 8-bit command byte after a start condition. Then it inserts an acknowledge and collects the word address. If the command's read flag (bit 0) is set, the block shifts out the byte it loaded at the end of the previous transaction, most significant bit first, while the address is being clocked in. When the address is complete, the block loads the addressed byte into its data register and inserts a second acknowledge. The counter then returns to idle.

The byte array takes its values from a parameter when reset is applied. The block has no write path into the array.

Top module: `serial_eeprom_resp`

## Requirements
- R1: While reset is applied and just after it is released, the returned data level is 1. The counter is idle and no acknowledge is pending.
- R2: Data falling while clock is high, both before and after an update, is a start condition. It restarts the counter at bit 1 and clears the command byte, and the counter never leaves the range 0 to 16.
- R3: While the counter is idle and no acknowledge is pending, clock edges have no effect. The returned level equals the data level of each update, and no acknowledge is ever inserted.
- R4: A rising clock is sampled as a bit only when the data level equals the stored level. If data changes in the same update as the rising clock, the bit is discarded and the counter does not advance.
- R5: After the eighth command bit, and after the last address bit, the next rising clock returns 0 whatever the update's data level. That edge clears the pending acknowledge and shifts no bit.
- R6: With command bit 0 set to 1, each rising clock of the address phase returns one bit of the data register, most significant bit first. The data register holds the byte loaded at the end of the preceding transaction, and 0 after reset.
- R7: With command bit 0 cleared, the returned level during the address phase equals the data level of each update. Once the address phase is complete, the data register is still loaded.
- R8: The array is preloaded with 0x80 at address 0, 0x08 at address 1, 0x04 at address 2 and 0x0D at address 3. Every other address, up to and including 0xFF, is preloaded with 0.
- R9: Data rising while clock stays high is a stop condition. It neither advances nor resets the counter.
- R10: The returned level changes only on updates. Between strobes it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; reloads the array |
| upd_valid | input | 1 | One-cycle strobe: a new clock/data pair is present |
| upd_scl | input | 1 | New serial clock level |
| upd_sda | input | 1 | New serial data level from the host |
| sda_ret | output | 1 | Data level the block leaves on the wire |

## Verification
The bench builds the block with its defaults: an 8-bit address, a full 256-entry array and a four-byte preload. These defaults make the highest address, 0xFF, reachable, and it is read back as 0. Read transactions are chained so that each transaction's address phase exposes the byte loaded by the one before it. A glitched first bit and a stop condition in the middle of a command byte each move the position of the acknowledge, so any error in the counter's handling of them shows up at the ports.

// File: rtl/serial_eeprom_resp.sv
module serial_eeprom_resp #(
  parameter int ADDR_W = 8,
  parameter int PRE_N  = 4,
  parameter logic [8*PRE_N-1:0] PRELOAD = 32'h80_08_04_0D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_valid,
  input  logic upd_scl,
  input  logic upd_sda,
  output logic sda_ret
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CMD_END = 9;
  localparam int ADR_END = CMD_END + ADDR_W;
  localparam int CNT_W   = $clog2(ADR_END + 1);

  logic              prev_scl;
  logic [CNT_W-1:0]  tick;
  logic [7:0]        cmd;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic              ack;
  logic [7:0]        mem [DEPTH];

  function automatic logic [7:0] pre_byte(input int k);
    pre_byte = 8'h00;
    for (int j = 0; j < PRE_N; j++)
      if (j == k) pre_byte = PRELOAD[8*(PRE_N-1-j) +: 8];
  endfunction

  wire               bus_edge = prev_scl & upd_scl & (sda_ret != upd_sda);
  wire               rise     = !prev_scl & upd_scl;
  wire               idle     = (tick == '0) && !ack;
  wire               bit_ok   = (sda_ret == upd_sda);
  wire [ADDR_W-1:0]  addr_nx  = {addr[ADDR_W-2:0], upd_sda};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int i = 0; i < DEPTH; i++) mem[i] <= pre_byte(i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl <= 1'b1;
      sda_ret  <= 1'b1;
      tick     <= '0;
      cmd      <= '0;
      addr     <= '0;
      data     <= '0;
      ack      <= 1'b0;
    end else if (upd_valid) begin
      prev_scl <= upd_scl;
      sda_ret  <= upd_sda;
      if (bus_edge) begin
        if (!upd_sda) begin
          tick <= CNT_W'(1);
          cmd  <= '0;
        end
      end else if (!idle && rise) begin
        if (ack) begin
          sda_ret <= 1'b0;
          ack     <= 1'b0;
        end else if (bit_ok) begin
          if (tick < CNT_W'(CMD_END)) begin
            cmd  <= {cmd[6:0], upd_sda};
            tick <= tick + CNT_W'(1);
            if (tick == CNT_W'(CMD_END - 1)) ack <= 1'b1;
          end else if (tick < CNT_W'(ADR_END)) begin
            if (cmd[0]) sda_ret <= data[7];
            addr <= addr_nx;
            if (tick == CNT_W'(ADR_END - 1)) begin
              data <= mem[addr_nx];
              ack  <= 1'b1;
              tick <= '0;
            end else begin
              data <= {data[6:0], 1'b0};
              tick <= tick + CNT_W'(1);
            end
          end else begin
            sda_ret <= 1'b0;
          end
        end
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(sda_ret));

  assert_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && ack && !prev_scl && upd_scl |=> !sda_ret);

  assert_idle_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (tick == '0) && !ack |=> sda_ret == $past(upd_sda));

  assert_stop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && prev_scl && upd_scl && !sda_ret && upd_sda |=> $stable(tick));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick < CNT_W'(ADR_END));

  assert_write_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !ack && (tick >= CNT_W'(CMD_END)) && !cmd[0]
    |=> sda_ret == $past(upd_sda));
endmodule

// File: tb/sim_serial_eeprom_resp.sv
module sim_serial_eeprom_resp;
  logic clk = 1'b0, rst_n = 1'b0, v = 1'b0, scl = 1'b1, sda = 1'b1;
  logic out;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];
  logic [7:0] last_data = 8'h00;

  always #4 clk = ~clk;

  serial_eeprom_resp u0 (.clk(clk), .rst_n(rst_n), .upd_valid(v),
                         .upd_scl(scl), .upd_sda(sda), .sda_ret(out));

  function automatic logic [7:0] mem_model(input logic [7:0] a);
    case (a)
      8'h00: return 8'h80;
      8'h01: return 8'h08;
      8'h02: return 8'h04;
      8'h03: return 8'h0D;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) if (v) begin
    bit e; string t;
    #2;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard: result with no expected item, actual %b expected none", out);
    end else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (out !== e) begin
        n_bad++;
        $display("FAIL %s: sda_ret=%b expected %b", t, out, e);
      end
    end
  end

  task automatic step(input logic c, input logic d, input logic e, input string t);
    @(negedge clk);
    scl = c; sda = d; v = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    v = 1'b0;
  endtask

  task automatic chk(input logic e, input string t);
    n_cmp++;
    if (out !== e) begin
      n_bad++;
      $display("FAIL %s: sda_ret=%b expected %b", t, out, e);
    end
  endtask

  task automatic clk_bit(input logic b, input logic e, input string t);
    step(1'b0, b, b, t);
    step(1'b1, b, e, t);
  endtask

  task automatic start_cond();
    step(1'b0, 1'b1, 1'b1, "R3");
    step(1'b1, 1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic xact(input logic [7:0] c, input logic [7:0] a, input string t,
                      input bit glitch, input int stop_after);
    start_cond();
    if (glitch) begin
      step(1'b0, 1'b0, 1'b0, "R4");
      step(1'b1, 1'b1, 1'b1, "R4");
    end
    for (int i = 7; i >= 0; i--) begin
      clk_bit(c[i], c[i], "R2");
      if ((8 - i) == stop_after && !c[i]) step(1'b1, 1'b1, 1'b1, "R9");
    end
    clk_bit(1'b1, 1'b0, "R5");
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = a[7-k];
      clk_bit(b, c[0] ? last_data[7-k] : b, t);
    end
    clk_bit(1'b1, 1'b0, "R5");
    last_data = mem_model(a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b1, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1 after reset");

    // R3: clocking with no start produces no acknowledge
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b1, "R3");
    clk_bit(1'b0, 1'b0, "R3");

    // R6: first read shows the reset value 0 of the data register
    xact(8'hA1, 8'h00, "R6", 1'b0, -1);
    // R10: output holds the acknowledge level with no strobes
    repeat (3) begin
      @(negedge clk);
      chk(1'b0, "R10");
    end

    // R8: chained reads expose the preloaded bytes
    xact(8'hA1, 8'h01, "R8", 1'b0, -1);
    xact(8'hA1, 8'h02, "R8", 1'b0, -1);
    xact(8'hA1, 8'hFF, "R8", 1'b0, -1);
    xact(8'hA1, 8'h03, "R8", 1'b0, -1);

    // R7: write command echoes the address bits
    xact(8'hA0, 8'h5A, "R7", 1'b0, -1);
    xact(8'hA1, 8'h00, "R7", 1'b0, -1);

    // R4: a bit with data changing on the rising clock is discarded
    xact(8'hA1, 8'h01, "R4", 1'b1, -1);

    // R9: a stop inside the command byte keeps the counter
    xact(8'hA1, 8'h02, "R9", 1'b0, 4);
    xact(8'hA1, 8'h00, "R6", 1'b0, -1);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule